// File: doc/BRIEF.md
# Multi-Source Memory Port Arbiter

This block decides which of several requesters owns a shared DRAM port. Four upper classes compete under fixed priority. In order, they are refresh, CPU interlocked (locked) access, floppy DMA, and CPU access to the buffered local bus. Below them sits a shared lowest tier in which the buffered local-bus slots and the peripheral I/O bus take turns.

Each requester has a request input and a grant output. A single common `done` strobe ends whatever grant is active. Grants are registered and one-hot. The arbiter makes a decision only while the port is idle. Once a grant is given, it is held until `done` is pulsed. The grant then drops on the next edge, and the following decision is made from the idle port one cycle later.

In the lowest tier, the peripheral bus is slotted in between successive local-bus slots. With every source asking, the order is slot 0, peripheral bus, slot 1, peripheral bus, slot 2, and so on. Positions whose owner is not requesting are skipped.

Top module: `mem_port_arbiter`

## Requirements
- R1: After reset all grant outputs are low, and the lowest-tier rotation starts at the slot 0 position.
- R2: While no grant is active, any asserted request produces exactly one grant on the next rising edge; with no request asserted no grant appears.
- R3: An active grant stays unchanged, whatever the request inputs do, until `done` is high at a rising edge; all grants are low after that edge.
- R4: `done` asserted while no grant is active has no effect: grants stay low and the lowest-tier rotation position is unchanged.
- R5: A refresh request wins over every other request.
- R6: Without refresh, priority is locked CPU access, then floppy, then CPU-to-local-bus, then the lowest tier.
- R7: In the lowest tier the rotation has 2×NUM_SLOTS positions: even position 2k belongs to slot k and every odd position to the peripheral bus. With all of them requesting, successive grants run slot 0, peripheral bus, slot 1, peripheral bus, and so on, wrapping after the last slot.
- R8: The search starts at the current rotation position and skips positions with no request; the position moves to one past the winner only when a lowest-tier grant is issued. Upper-tier grants leave it unchanged.
- R9: Grants are registered: a request first seen at an edge is granted at that edge, never before. At most one grant output is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| refresh_req | input | 1 | Refresh request |
| lock_req | input | 1 | CPU interlocked access request |
| floppy_req | input | 1 | Floppy DMA request |
| cpu_bus_req | input | 1 | CPU access to buffered local bus |
| slot_req | input | NUM_SLOTS | Local-bus slot requests, bit k = slot k |
| pbus_req | input | 1 | Peripheral I/O bus request |
| done | input | 1 | Ends the active grant |
| refresh_gnt | output | 1 | Refresh grant |
| lock_gnt | output | 1 | Interlocked access grant |
| floppy_gnt | output | 1 | Floppy grant |
| cpu_bus_gnt | output | 1 | CPU-to-local-bus grant |
| slot_gnt | output | NUM_SLOTS | Slot grants, bit k = slot k |
| pbus_gnt | output | 1 | Peripheral bus grant |

## Verification
A corrupted rotation position would not show at the grant of the current decision. It shows only at the next lowest-tier decision in which several positions are requesting, as a grant to the wrong slot or to the peripheral bus out of turn. For that reason the vectors chain decisions and interleave upper-tier grants between lowest-tier ones. A stuck or leaking grant register shows within one edge: a second grant bit appears, a grant drops without `done`, or the port stays granted after `done`.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    localparam int UPPER_N = 4;

    // Upper-tier request set; bit 0 (refresh) has the highest rank.
    typedef struct packed {
        logic cpu_bus;
        logic floppy;
        logic lock;
        logic refresh;
    } upper_req_t;

    // Isolate the lowest set bit (fixed priority, bit 0 first).
    function automatic logic [UPPER_N-1:0] lowest_hot(input logic [UPPER_N-1:0] v);
        return v & (~v + UPPER_N'(1));
    endfunction

endpackage

// File: rtl/mpa_upper_pick.sv
module mpa_upper_pick
    import mpa_pkg::*;
(
    input  upper_req_t               req,
    output logic [UPPER_N-1:0]       pick,
    output logic                     any
);
    always_comb begin
        pick = lowest_hot(req);
        any  = |req;
    end
endmodule

// File: rtl/mpa_low_rotor.sv
module mpa_low_rotor #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic                 pbus_req,
    input  logic                 commit,
    output logic                 valid,
    output logic [NUM_SLOTS-1:0] slot_pick,
    output logic                 pbus_pick
);
    localparam int POS_N = 2 * NUM_SLOTS;
    localparam int POS_W = (POS_N > 1) ? $clog2(POS_N) : 1;

    logic [POS_N-1:0] pos_req;
    logic [POS_W-1:0] ptr_q;
    logic [POS_W-1:0] win_pos;

    // Even positions carry the slots, odd positions the peripheral bus.
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_pos
        assign pos_req[2*k]   = slot_req[k];
        assign pos_req[2*k+1] = pbus_req;
        assign slot_pick[k]   = valid && (win_pos == POS_W'(2*k));
    end
    assign pbus_pick = valid && win_pos[0];

    always_comb begin
        valid   = 1'b0;
        win_pos = ptr_q;
        for (int i = 0; i < POS_N; i++) begin
            int pos;
            pos = (int'(ptr_q) + i) % POS_N;
            if (!valid && pos_req[pos]) begin
                valid   = 1'b1;
                win_pos = POS_W'(pos);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (commit)
            ptr_q <= (win_pos == POS_W'(POS_N-1)) ? '0 : win_pos + POS_W'(1);
    end

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(ptr_q)); // R8
    AST_PICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pbus_pick, slot_pick})); // R7
    AST_PICK_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        pbus_pick |-> pbus_req); // R8

endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
    import mpa_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 refresh_req,
    input  logic                 lock_req,
    input  logic                 floppy_req,
    input  logic                 cpu_bus_req,
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic                 pbus_req,
    input  logic                 done,
    output logic                 refresh_gnt,
    output logic                 lock_gnt,
    output logic                 floppy_gnt,
    output logic                 cpu_bus_gnt,
    output logic [NUM_SLOTS-1:0] slot_gnt,
    output logic                 pbus_gnt
);
    localparam int NSRC     = UPPER_N + NUM_SLOTS + 1;
    localparam int PBUS_BIT = UPPER_N + NUM_SLOTS;

    upper_req_t            up_req;
    logic [UPPER_N-1:0]    up_pick;
    logic                  up_any;
    logic                  low_valid;
    logic [NUM_SLOTS-1:0]  low_slot;
    logic                  low_pbus;
    logic                  idle;
    logic                  commit;
    logic [NSRC-1:0]       gnt_q;
    logic [NSRC-1:0]       win_vec;

    assign up_req = '{cpu_bus: cpu_bus_req, floppy: floppy_req,
                      lock: lock_req, refresh: refresh_req};

    mpa_upper_pick u_upper (
        .req  (up_req),
        .pick (up_pick),
        .any  (up_any)
    );

    mpa_low_rotor #(.NUM_SLOTS(NUM_SLOTS)) u_rotor (
        .clk       (clk),
        .rst       (rst),
        .slot_req  (slot_req),
        .pbus_req  (pbus_req),
        .commit    (commit),
        .valid     (low_valid),
        .slot_pick (low_slot),
        .pbus_pick (low_pbus)
    );

    assign idle    = (gnt_q == '0);
    assign commit  = idle && !up_any && low_valid;
    assign win_vec = {low_pbus && !up_any, low_slot & {NUM_SLOTS{!up_any}}, up_pick};

    always_ff @(posedge clk) begin
        if (rst)
            gnt_q <= '0;
        else if (idle)
            gnt_q <= win_vec;
        else if (done)
            gnt_q <= '0;
    end

    assign refresh_gnt = gnt_q[0];
    assign lock_gnt    = gnt_q[1];
    assign floppy_gnt  = gnt_q[2];
    assign cpu_bus_gnt = gnt_q[3];
    assign slot_gnt    = gnt_q[UPPER_N +: NUM_SLOTS];
    assign pbus_gnt    = gnt_q[PBUS_BIT];

    logic any_req;
    assign any_req = up_any || (|slot_req) || pbus_req;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_q)); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!idle && !done) |=> $stable(gnt_q)); // R3
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!idle && done) |=> (gnt_q == '0)); // R3
    AST_SERVE: assert property (@(posedge clk) disable iff (rst)
        (idle && any_req) |=> (gnt_q != '0)); // R2
    AST_IDLE_DONE: assert property (@(posedge clk) disable iff (rst)
        (idle && done && !any_req) |=> (gnt_q == '0)); // R4
    AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (rst)
        (idle && refresh_req) |=> refresh_gnt); // R5
    AST_LOCK_SECOND: assert property (@(posedge clk) disable iff (rst)
        (idle && lock_req && !refresh_req) |=> lock_gnt); // R6

endmodule

// File: tb/test_mem_port_arbiter.sv
`timescale 1ns/1ps
module test_mem_port_arbiter;
    localparam int NS = 4;
    localparam int NV = 17;
    // Layout: bit0 refresh, 1 lock, 2 floppy, 3 cpu_bus, 4..7 slot0..3, 8 pbus
    localparam logic [8:0] REQ_V [NV] = '{
        9'h1FF, 9'h1FE, 9'h1FC, 9'h1F8, 9'h1F0, 9'h1F0, 9'h1F0, 9'h1F0,
        9'h1F0, 9'h080, 9'h050, 9'h100, 9'h030, 9'h042, 9'h150, 9'h050, 9'h000};
    localparam logic [8:0] EXP_V [NV] = '{
        9'h001, 9'h002, 9'h004, 9'h008, 9'h010, 9'h100, 9'h020, 9'h100,
        9'h040, 9'h080, 9'h010, 9'h100, 9'h020, 9'h002, 9'h100, 9'h040, 9'h000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic refresh_req = 0, lock_req = 0, floppy_req = 0, cpu_bus_req = 0, pbus_req = 0, done = 0;
    logic [NS-1:0] slot_req = '0;
    logic refresh_gnt, lock_gnt, floppy_gnt, cpu_bus_gnt, pbus_gnt;
    logic [NS-1:0] slot_gnt;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    mem_port_arbiter #(.NUM_SLOTS(NS)) i_mem_port_arbiter (
        .clk(clk), .rst(rst), .refresh_req(refresh_req), .lock_req(lock_req),
        .floppy_req(floppy_req), .cpu_bus_req(cpu_bus_req), .slot_req(slot_req),
        .pbus_req(pbus_req), .done(done), .refresh_gnt(refresh_gnt), .lock_gnt(lock_gnt),
        .floppy_gnt(floppy_gnt), .cpu_bus_gnt(cpu_bus_gnt), .slot_gnt(slot_gnt),
        .pbus_gnt(pbus_gnt));

    function automatic logic [8:0] grants();
        return {pbus_gnt, slot_gnt, cpu_bus_gnt, floppy_gnt, lock_gnt, refresh_gnt};
    endfunction

    task automatic drive(input logic [8:0] v);
        {pbus_req, slot_req, cpu_bus_req, floppy_req, lock_req, refresh_req} = v;
    endtask

    task automatic check(input string tag, input logic [8:0] exp);
        total++;
        if (grants() !== exp) begin
            bad++;
            $display("FAIL %s: grant=%h expected=%h", tag, grants(), exp);
        end
    endtask

    // One decision from an idle port: request, sample grant, release with done.
    task automatic decide(input string tag, input logic [8:0] req, input logic [8:0] exp);
        drive(req);
        @(negedge clk);
        check(tag, exp);
        drive('0);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog: grant=%h expected=run to end", grants());
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", 9'h000);

        for (int i = 0; i < NV; i++) begin
            string tag;
            if (i == 0)       tag = "R5 refresh first";
            else if (i < 4)   tag = "R6 fixed order";
            else if (i < 9)   tag = "R7 interleave";
            else              tag = "R8 skip and hold";
            decide($sformatf("%s row %0d", tag, i), REQ_V[i], EXP_V[i]);
        end
        // rotation now at position 5 (peripheral bus)

        // R4: done while idle has no effect on grants or rotation
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check("R4 idle done grants", 9'h000);
        decide("R4 rotation kept", 9'h1F0, 9'h100);

        // R9: registered grant, R3: hold while requests change
        drive(9'h004);
        #1;
        check("R9 not before edge", 9'h000);
        @(negedge clk);
        check("R9 granted at edge", 9'h004);
        drive(9'h001);
        repeat (3) @(negedge clk);
        check("R3 held without done", 9'h004);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check("R3 released after done", 9'h000);
        @(negedge clk);
        check("R2 pending served", 9'h001);
        drive('0);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);
        check("R2 no request no grant", 9'h000);

        // R1: reset returns rotation to slot 0 (it stood at slot 3 position)
        decide("R7 pre-reset slot3", 9'h0C0, 9'h080);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears", 9'h000);
        decide("R1 rotation at slot0", 9'h1F0, 9'h010);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule